// File: doc/BRIEF.md
# One-Shot Down-Counting Interrupt Timer

This block is a memory-mapped one-shot timer. Software programs a start value while the timer is stopped, then sets the enable bit. From that point the counter steps down once for every strobe from one of four external tick sources: a slow clock near 32 kHz, a 26 MHz reference, the CPU clock or the peripheral clock. When the count runs out, the block latches a pending flag and holds the counter at zero. If the interrupt is enabled, the pending flag drives the interrupt line until software clears it.

Four word registers sit on a simple bus with single-cycle requests. Reads return data on the cycle after the request. The control word holds the enable and the source select. The reload word can be written only while the timer is stopped. The current-count word reads zero while the timer is stopped. The interrupt word uses bit 4 for two jobs: on read it shows the pending status, and on write it sets the interrupt enable. Writing one to bit 5 clears the pending flag. The tick generators themselves are outside this block.

Top module: `oneshot_dtimer`

## Requirements
- R1: After reset the enable, the source select, the reload value, the interrupt enable, the pending flag and `irq` are all zero. Every register reads zero.
- R2: The word at byte offset 0x0 is control, with enable in bit 0 and source select in bits [5:4]. The reload value is at 0x4, the current count at 0x8 and interrupt status/ack at 0xC. `bus_rdata` holds the addressed word from the cycle after a read request.
- R3: A reload write is accepted only while enable is 0. A reload write made while the timer is enabled leaves the stored reload value unchanged.
- R4: While enable is 0, the current-count word reads zero.
- R5: A control write that changes enable from 0 to 1 loads the reload value into the counter. A control write that keeps enable at 1 does not reload it.
- R6: While the timer is enabled and running, the counter decrements only on a strobe of `tick_src[sel]`. The select codes are 0 = slow, 1 = reference, 2 = CPU, 3 = peripheral. Strobes on the other three sources have no effect.
- R7: With reload N ≥ 1, the pending flag sets on the Nth selected strobe. With reload 0, it sets on the first selected strobe. After expiry the counter stays at zero.
- R8: Bit 4 of the interrupt word reads as the pending flag. A write to that word copies data bit 4 into the interrupt enable.
- R9: Writing to the interrupt word with data bit 5 set clears the pending flag. If an expiry happens in the same cycle, the expiry wins and the flag stays set.
- R10: `irq` is a register that takes (pending AND interrupt enable) at each clock. It follows that value one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_src | input | 4 | Tick strobes: [0] slow, [1] reference, [2] CPU, [3] peripheral |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with an 8-bit counter. This keeps the stored reload narrow, while the bus stays 32 bits wide. The bench sweeps every source select against reload values 0 through 9. For each pair it counts strobes one by one up to expiry and computes the expected count arithmetically. Strobes on the unselected sources are injected between the counting strobes. Directed cases cover writes while enabled, disabling mid-count, re-enabling while already enabled, a masked interrupt, and a clear that lands in the same cycle as an expiry.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  // Word indices within the register window
  localparam logic [1:0] W_CTRL   = 2'd0;
  localparam logic [1:0] W_RELOAD = 2'd1;
  localparam logic [1:0] W_COUNT  = 2'd2;
  localparam logic [1:0] W_INTR   = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_LSB = 4;
  localparam int INTR_ST_BIT  = 4;
  localparam int INTR_CLR_BIT = 5;

  typedef enum logic [1:0] {
    SRC_SLOW   = 2'd0,
    SRC_REF    = 2'd1,
    SRC_CPU    = 2'd2,
    SRC_PERIPH = 2'd3
  } tick_src_e;
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [1:0]        word,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  reload,
  output logic              ie,
  output logic              start,
  output logic              reload_wr,
  output logic              clr_req
);
  logic ctrl_wr, intr_wr;

  always_comb begin
    ctrl_wr   = wr_stb && (word == W_CTRL);
    intr_wr   = wr_stb && (word == W_INTR);
    reload_wr = wr_stb && (word == W_RELOAD) && !en;
    start     = ctrl_wr && wdata[CTRL_EN_BIT] && !en;
    clr_req   = intr_wr && wdata[INTR_CLR_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      sel    <= '0;
      reload <= '0;
      ie     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en  <= wdata[CTRL_EN_BIT];
        sel <= wdata[CTRL_SEL_LSB +: SEL_W];
      end
      if (reload_wr) reload <= wdata[CNT_W-1:0];
      if (intr_wr)   ie     <= wdata[INTR_ST_BIT];
    end
  end

  // R3
  reload_locked_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(reload));
endmodule

// File: rtl/dtmr_tick_mux.sv
module dtmr_tick_mux #(
  parameter int NSRC  = 4,
  parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  tick_src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = tick_src[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  input  logic             clr_req,
  output logic [CNT_W-1:0] count,
  output logic             pending
);
  logic running;
  logic expire;

  assign expire = en && running && tick && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
    end else if (start) begin
      count   <= reload;
      running <= 1'b1;
    end else if (reload_wr) begin
      count   <= '0;
      running <= 1'b0;
    end else if (!en) begin
      running <= 1'b0;
    end else if (running && tick) begin
      if (expire) begin
        count   <= '0;
        running <= 1'b0;
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (expire)  pending <= 1'b1;
    else if (clr_req) pending <= 1'b0;
  end

  // R6
  no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !reload_wr) |=> (count <= $past(count)));
  // R7
  hold_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !start && !reload_wr) |=> $stable(count));
  // R9
  pending_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !clr_req) |=> pending);
endmodule

// File: rtl/oneshot_dtimer.sv
module oneshot_dtimer
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int NSRC   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   tick_src,
  output logic              irq
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [1:0]       word;
  logic             en, ie, start, reload_wr, clr_req, tick, pending;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] reload, count;
  logic [DATA_W-1:0] rd_next;

  assign word = bus_addr[3:2];

  dtmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(bus_sel && bus_wr), .word(word),
    .wdata(bus_wdata), .en(en), .sel(sel), .reload(reload), .ie(ie),
    .start(start), .reload_wr(reload_wr), .clr_req(clr_req)
  );

  dtmr_tick_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .tick_src(tick_src), .sel(sel), .tick(tick)
  );

  dtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(en), .start(start), .reload_wr(reload_wr),
    .reload(reload), .tick(tick), .clr_req(clr_req),
    .count(count), .pending(pending)
  );

  always_comb begin
    rd_next = '0;
    unique case (word)
      W_CTRL: begin
        rd_next[CTRL_EN_BIT]              = en;
        rd_next[CTRL_SEL_LSB +: SEL_W]    = sel;
      end
      W_RELOAD: rd_next = DATA_W'(reload);
      W_COUNT:  rd_next = en ? DATA_W'(count) : '0;
      W_INTR:   rd_next[INTR_ST_BIT] = pending;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_sel && !bus_wr) bus_rdata <= rd_next;
      irq <= pending && ie;
    end
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && ie) |=> irq);
  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == $past(reload)));
endmodule

// File: tb/oneshot_dtimer_bench.sv
module oneshot_dtimer_bench;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = '0;
  logic        irq;

  int checks = 0, failures = 0, cycles = 0;

  always #4 clk = ~clk;

  oneshot_dtimer #(.DATA_W(32), .CNT_W(CW), .NSRC(4), .ADDR_W(4)) u_oneshot_dtimer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_src(tick_src), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic tk(input logic [3:0] m);
    tick_src = m;
    @(negedge clk);
    tick_src = '0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 0);
    rd(4'h4, v); chk("R1 reload", v, 0);
    rd(4'h8, v); chk("R1 count", v, 0);
    rd(4'hC, v); chk("R1 intr", v, 0);
    chk("R1 irq", irq, 0);

    // Sweep all sources against reload values 0..9 (R2 R5 R6 R7 R8 R9 R10)
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 10; n++) begin
        int t;
        t = (n == 0) ? 1 : n;
        wr(4'h0, 32'(s) << 4);
        wr(4'h4, 32'(n));
        wr(4'hC, 32'h30);
        wr(4'h0, (32'(s) << 4) | 32'h1);
        rd(4'h0, v); chk("R2 ctrl readback", v, (32'(s) << 4) | 32'h1);
        rd(4'h8, v); chk("R5 load on enable", v, 32'(n));
        for (int k = 1; k <= t; k++) begin
          tk(4'hF & ~(4'h1 << s));
          if (k == 1) begin
            rd(4'h8, v); chk("R6 other sources ignored", v, 32'(n));
          end
          rd(4'hC, v); chk("R7 not yet pending", v, 0);
          tk(4'h1 << s);
          rd(4'h8, v); chk("R6 count step", v, (n > k) ? 32'(n - k) : 0);
        end
        rd(4'hC, v); chk("R8 status pending", v, 32'h10);
        chk("R10 irq raised", irq, 1);
        tk(4'h1 << s);
        rd(4'h8, v); chk("R7 held at zero", v, 0);
        wr(4'hC, 32'h30);
        rd(4'hC, v); chk("R9 cleared", v, 0);
        chk("R10 irq dropped", irq, 0);
      end
    end

    // R3 / R4 / R5: locked reload, zero read while disabled, restart
    wr(4'h0, 32'h10);
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h11);
    wr(4'h4, 32'd3);
    rd(4'h4, v); chk("R3 reload locked", v, 5);
    tk(4'h2); tk(4'h2);
    rd(4'h8, v); chk("R6 mid count", v, 3);
    wr(4'h0, 32'h11);
    rd(4'h8, v); chk("R5 no reload while enabled", v, 3);
    wr(4'h0, 32'h10);
    rd(4'h8, v); chk("R4 zero while disabled", v, 0);
    wr(4'h0, 32'h11);
    rd(4'h8, v); chk("R5 restart from reload", v, 5);

    // R8 / R10: masked interrupt
    wr(4'h0, 32'h10);
    wr(4'h4, 32'd2);
    wr(4'hC, 32'h20);
    wr(4'h0, 32'h11);
    tk(4'h2); tk(4'h2);
    rd(4'hC, v); chk("R8 status with ie off", v, 32'h10);
    chk("R10 irq masked", irq, 0);
    wr(4'hC, 32'h10);
    rd(4'hC, v); chk("R8 enable keeps pending", v, 32'h10);
    chk("R10 irq after enable", irq, 1);
    wr(4'hC, 32'h00);
    rd(4'hC, v); chk("R8 ie off keeps pending", v, 32'h10);
    chk("R10 irq after disable", irq, 0);

    // R9: clear coincides with expiry
    wr(4'h0, 32'h10);
    wr(4'h4, 32'd1);
    wr(4'hC, 32'h30);
    wr(4'h0, 32'h11);
    tick_src = 4'h2;
    wr(4'hC, 32'h30);
    tick_src = '0;
    rd(4'hC, v); chk("R9 expiry beats clear", v, 32'h10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule